// File: doc/BRIEF.md
# PCI Function Configuration Register File

This block holds the configuration header of a single PCI function, including the six Base Address Registers (BARs). A host-side agent sends it one access at a time over a valid/ready request channel. Each access is a read or a write of 1, 2 or 4 naturally aligned bytes at a byte offset inside a 256-byte window. Every accepted request returns exactly one response on a valid/ready response channel. The response carries the read data, zero-extended and little-endian, and an error flag. Identity fields come from parameters and cannot be changed. The command byte pair, cache-line size, latency timer and interrupt line can be written.

Each BAR runs the standard sizing handshake. A full-word write of all ones makes the BAR read back a mask derived from its power-of-two size, and the type bits are kept. A later write with a non-zero address programs a decode base, which is offset into a fixed I/O or memory window depending on the BAR's space bit. For each BAR the block drives the decoded base, a decode enable and a one-cycle range-change pulse, so that an address decoder beside it can claim transactions.

Back-pressure rules: a request is taken in any cycle where `req_valid` and `req_ready` are both high. `req_ready` is high whenever no response is waiting, or the waiting response is being taken in the same cycle. The response appears one cycle after acceptance. It stays unchanged until `rsp_ready` is seen high. Each BAR size parameter must be zero or a power of two; any other value stops elaboration with an error.

Top module: `cfg_space_regs`

## Requirements
- R1: After reset every decoded base is 0, every decode enable is 0, the command register reads 0, and each sized BAR reads only its initial type bits (BAR0 reads 0x1, BAR2 reads 0x8 with the default parameters).
- R2: Reads return the addressed bytes zero-extended. A byte at offset o lands in bits [7:0] and a halfword at offset o holds byte o in bits [7:0]. Dword 0 reads {device id, vendor id}, and dword 15 reads {16'h0, interrupt pin, interrupt line}.
- R3: `req_size` encodes 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes. The following complete with `rsp_err`=1, read data 0 and no state change: size 3, a halfword at an odd offset, a word at an offset not divisible by 4, or an offset of 256 or more.
- R4: The writable header bytes are 0x04, 0x05 (command), 0x0C, 0x0D and 0x3C. Any write to header bytes outside that set is ignored in full and returns `rsp_err`=1. A write inside the set returns `rsp_err`=0.
- R5: A full-word write of 0xFFFFFFFF to a sized BAR makes it read ~(size-1) above its type bits, with the type bits unchanged. The decoded base is left unchanged and no range-change pulse is raised.
- R6: Bit 0 of a BAR is its space bit (1 = I/O). I/O BARs keep bits [1:0] and memory BARs keep bits [3:0] against every write.
- R7: A full-word BAR write, other than all ones, whose value with the type bits cleared is non-zero stores that value. It sets the decoded base to the value plus IO_WIN_BASE (I/O) or MEM_WIN_BASE (memory), and raises `bar_range_chg[i]` for exactly the response cycle.
- R8: A full-word BAR write whose value is zero once the type bits are cleared stores zero above the type bits. It leaves the decoded base unchanged and raises no range-change pulse.
- R9: `bar_enable[i]` is high when BAR i has been given a base and the matching command bit is set: bit 0 for I/O, bit 1 for memory.
- R10: A BAR whose size parameter is 0 reads 0. Full-word writes to it are ignored without error, and its enable, base and pulse stay 0.
- R11: A 1- or 2-byte write to a BAR dword (offsets 0x10 to 0x27) is ignored and returns `rsp_err`=1.
- R12: Each accepted request gives one response in the next cycle. The response holds its data and error flag while `rsp_ready` is low, and `req_ready` is low during that time. Write responses carry data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access width code (R3) |
| req_offset | input | OFF_W (12) | Byte offset in the configuration window |
| req_wdata | input | 32 | Write data, right-justified |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | 32 | Read data, zero-extended |
| rsp_err | output | 1 | Access rejected |
| bar_base | output | NUM_BARS*32 | Decoded base of BAR i in bits [32*i+31:32*i] |
| bar_enable | output | NUM_BARS | Decode enable per BAR |
| bar_range_chg | output | NUM_BARS | One-cycle pulse when a BAR's base is set |

## Verification
The bench targets the sizing write and checks that the type bits survive. A design that masked with the wrong width, or that chose the mask by the new data rather than the stored space bit, would read back a corrupted low nibble. Zero-after-mask writes, and writes to a zero-size BAR, check that the base and the range pulse stay put; a design that treated every write as programming would move the decoder's window to the bare window base. Sub-word BAR writes, writes to identity bytes and misaligned or out-of-window offsets must all come back with the error flag and leave the registers untouched. A held response under back-pressure must neither change nor let a second request in, because a design that drops or overwrites it would lose a read.

// File: rtl/cfgsp_pkg.sv
package cfgsp_pkg;

  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_HALF = 2'd1,
    ACC_WORD = 2'd2,
    ACC_NONE = 2'd3
  } acc_size_e;

  // First BAR sits in dword 4 (byte 0x10); decoders depend on this.
  localparam int unsigned BAR_DW_FIRST = 4;
  localparam logic [31:0] SIZING_WORD  = 32'hFFFF_FFFF;
  localparam logic [31:0] IO_KEEP      = 32'h0000_0003;
  localparam logic [31:0] MEM_KEEP     = 32'h0000_000F;

  function automatic logic size_legal(input logic [31:0] s);
    return (s == 32'd0) || ((s & (s - 32'd1)) == 32'd0);
  endfunction

  function automatic logic [31:0] keep_mask(input logic space_io);
    return space_io ? IO_KEEP : MEM_KEEP;
  endfunction

  // Byte-lane write permission for header dwords (BAR dwords excluded).
  function automatic logic [3:0] hdr_lane_wr(input logic [7:0] dw);
    case (dw)
      8'd1:    return 4'b0011;
      8'd3:    return 4'b0011;
      8'd15:   return 4'b0001;
      default: return 4'b0000;
    endcase
  endfunction

endpackage

// File: rtl/cfgsp_access.sv
module cfgsp_access
  import cfgsp_pkg::*;
#(
  parameter int OFF_W     = 12,
  parameter int WIN_BYTES = 256,
  localparam int DWI_W    = $clog2(WIN_BYTES / 4)
) (
  input  logic [OFF_W-1:0] offset,
  input  logic [1:0]       size,
  input  logic [31:0]      wdata,
  output logic [DWI_W-1:0] dw_idx,
  output logic [1:0]       lane,
  output logic [3:0]       be,
  output logic [31:0]      wlane,
  output logic             bad
);

  logic out_of_window;
  logic misaligned;

  assign out_of_window = ({1'b0, offset} >= (OFF_W+1)'(WIN_BYTES));
  assign lane          = offset[1:0];
  assign dw_idx        = offset[DWI_W+1:2];
  assign wlane         = wdata << {offset[1:0], 3'b000};

  always_comb begin
    misaligned = 1'b0;
    be         = 4'b0000;
    case (acc_size_e'(size))
      ACC_BYTE: be = 4'b0001 << offset[1:0];
      ACC_HALF: begin
        misaligned = offset[0];
        be         = 4'b0011 << offset[1:0];
      end
      ACC_WORD: begin
        misaligned = (offset[1:0] != 2'b00);
        be         = 4'b1111;
      end
      default:  misaligned = 1'b1;
    endcase
  end

  assign bad = out_of_window | misaligned;

endmodule

// File: rtl/cfgsp_hdr.sv
module cfgsp_hdr
  import cfgsp_pkg::*;
#(
  parameter int          DWI_W     = 6,
  parameter logic [15:0] VENDOR_ID = 16'hC0DE,
  parameter logic [15:0] DEVICE_ID = 16'h5A17,
  parameter logic [31:0] CLASS_REV = 32'h0200_0001,
  parameter logic [31:0] SUBSYS_ID = 32'h0001_C0DE,
  parameter logic [7:0]  HDR_TYPE  = 8'h00,
  parameter logic [7:0]  INT_PIN   = 8'h01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [DWI_W-1:0] dw_idx,
  input  logic [3:0]       be,
  input  logic [31:0]      wlane,
  output logic [31:0]      rd_dword,
  output logic             ro_hit,
  output logic [15:0]      cmd
);

  logic [15:0] cmd_q;
  logic [7:0]  cline_q;
  logic [7:0]  lat_q;
  logic [7:0]  irq_line_q;
  logic [7:0]  dw8;

  assign dw8    = 8'(dw_idx);
  assign ro_hit = |(be & ~hdr_lane_wr(dw8));
  assign cmd    = cmd_q;

  always_comb begin
    case (dw8)
      8'd0:    rd_dword = {DEVICE_ID, VENDOR_ID};
      8'd1:    rd_dword = {16'h0000, cmd_q};
      8'd2:    rd_dword = CLASS_REV;
      8'd3:    rd_dword = {8'h00, HDR_TYPE, lat_q, cline_q};
      8'd11:   rd_dword = SUBSYS_ID;
      8'd15:   rd_dword = {16'h0000, INT_PIN, irq_line_q};
      default: rd_dword = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q      <= '0;
      cline_q    <= '0;
      lat_q      <= '0;
      irq_line_q <= '0;
    end else if (wr) begin
      case (dw8)
        8'd1: begin
          if (be[0]) cmd_q[7:0]  <= wlane[7:0];
          if (be[1]) cmd_q[15:8] <= wlane[15:8];
        end
        8'd3: begin
          if (be[0]) cline_q <= wlane[7:0];
          if (be[1]) lat_q   <= wlane[15:8];
        end
        8'd15: begin
          if (be[0]) irq_line_q <= wlane[7:0];
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/cfgsp_bar.sv
module cfgsp_bar
  import cfgsp_pkg::*;
#(
  parameter logic [31:0] SIZE         = 32'h100,
  parameter logic [31:0] INIT         = 32'h1,
  parameter logic [31:0] IO_WIN_BASE  = 32'h4000_0000,
  parameter logic [31:0] MEM_WIN_BASE = 32'h8000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [31:0] wdata,
  output logic [31:0] value,
  output logic [31:0] dec_base,
  output logic        programmed,
  output logic        range_evt
);

  localparam bit          ACTIVE   = (SIZE != 32'd0);
  localparam logic [31:0] RST_VAL  = INIT & keep_mask(INIT[0]);
  localparam logic [31:0] SIZE_PAT = ~(SIZE - 32'd1);

  logic [31:0] val_q, base_q;
  logic        prog_q, evt_q;
  logic [31:0] keep, addr_part;
  logic        sizing;

  assign keep      = keep_mask(val_q[0]);
  assign addr_part = wdata & ~keep;
  assign sizing    = (wdata == SIZING_WORD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_q  <= RST_VAL;
      base_q <= '0;
      prog_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      evt_q <= 1'b0;
      if (ACTIVE && wr) begin
        if (sizing) begin
          val_q <= (SIZE_PAT & ~keep) | (val_q & keep);
        end else begin
          val_q <= addr_part | (val_q & keep);
          if (addr_part != 32'd0) begin
            base_q <= addr_part + (val_q[0] ? IO_WIN_BASE : MEM_WIN_BASE);
            prog_q <= 1'b1;
            evt_q  <= 1'b1;
          end
        end
      end
    end
  end

  assign value      = ACTIVE ? val_q  : 32'd0;
  assign dec_base   = ACTIVE ? base_q : 32'd0;
  assign programmed = ACTIVE & prog_q;
  assign range_evt  = ACTIVE & evt_q;

endmodule

// File: rtl/cfg_space_regs.sv
module cfg_space_regs
  import cfgsp_pkg::*;
#(
  parameter int          NUM_BARS     = 6,
  parameter int          OFF_W        = 12,
  parameter int          WIN_BYTES    = 256,
  parameter logic [NUM_BARS*32-1:0] BAR_SIZES =
    {32'd0, 32'd16, 32'd0, 32'h0001_0000, 32'h0000_1000, 32'h0000_0100},
  parameter logic [NUM_BARS*32-1:0] BAR_INIT =
    {32'd0, 32'd1, 32'd0, 32'd8, 32'd0, 32'd1},
  parameter logic [31:0] IO_WIN_BASE  = 32'h4000_0000,
  parameter logic [31:0] MEM_WIN_BASE = 32'h8000_0000,
  parameter logic [15:0] VENDOR_ID    = 16'hC0DE,
  parameter logic [15:0] DEVICE_ID    = 16'h5A17,
  parameter logic [31:0] CLASS_REV    = 32'h0200_0001,
  parameter logic [31:0] SUBSYS_ID    = 32'h0001_C0DE,
  parameter logic [7:0]  HDR_TYPE     = 8'h00,
  parameter logic [7:0]  INT_PIN      = 8'h01
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [1:0]            req_size,
  input  logic [OFF_W-1:0]      req_offset,
  input  logic [31:0]           req_wdata,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [31:0]           rsp_rdata,
  output logic                  rsp_err,
  output logic [NUM_BARS*32-1:0] bar_base,
  output logic [NUM_BARS-1:0]   bar_enable,
  output logic [NUM_BARS-1:0]   bar_range_chg
);

  localparam int DWI_W = $clog2(WIN_BYTES / 4);

  logic [DWI_W-1:0] dw_idx;
  logic [1:0]       lane;
  logic [3:0]       be;
  logic [31:0]      wlane;
  logic             acc_bad;

  cfgsp_access #(.OFF_W(OFF_W), .WIN_BYTES(WIN_BYTES)) u_acc (
    .offset (req_offset),
    .size   (req_size),
    .wdata  (req_wdata),
    .dw_idx (dw_idx),
    .lane   (lane),
    .be     (be),
    .wlane  (wlane),
    .bad    (acc_bad)
  );

  logic        fire;
  logic        is_bar;
  logic        wr_ok;
  logic        wr_reject;
  logic        hdr_ro_hit;
  logic [31:0] hdr_dword;
  logic [15:0] cmd;

  assign req_ready = ~rsp_valid | rsp_ready;
  assign fire      = req_valid & req_ready;
  assign is_bar    = ({1'b0, dw_idx} >= (DWI_W+1)'(BAR_DW_FIRST)) &&
                     ({1'b0, dw_idx} <  (DWI_W+1)'(BAR_DW_FIRST + NUM_BARS));
  assign wr_reject = is_bar ? (be != 4'hF) : hdr_ro_hit;
  assign wr_ok     = fire & req_write & ~acc_bad & ~wr_reject;

  cfgsp_hdr #(
    .DWI_W(DWI_W), .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID),
    .CLASS_REV(CLASS_REV), .SUBSYS_ID(SUBSYS_ID),
    .HDR_TYPE(HDR_TYPE), .INT_PIN(INT_PIN)
  ) u_hdr (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (wr_ok & ~is_bar),
    .dw_idx   (dw_idx),
    .be       (be),
    .wlane    (wlane),
    .rd_dword (hdr_dword),
    .ro_hit   (hdr_ro_hit),
    .cmd      (cmd)
  );

  logic [31:0]         bar_val [NUM_BARS];
  logic [NUM_BARS-1:0] bar_prog;

  for (genvar gi = 0; gi < NUM_BARS; gi++) begin : g_bar
    localparam logic [31:0] SZ = BAR_SIZES[gi*32 +: 32];
    if (!size_legal(SZ)) begin : g_bad_size
      $error("BAR size parameter must be zero or a power of two");
    end
    cfgsp_bar #(
      .SIZE(SZ), .INIT(BAR_INIT[gi*32 +: 32]),
      .IO_WIN_BASE(IO_WIN_BASE), .MEM_WIN_BASE(MEM_WIN_BASE)
    ) u_bar (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr         (wr_ok && is_bar &&
                   (dw_idx == DWI_W'(BAR_DW_FIRST + gi))),
      .wdata      (req_wdata),
      .value      (bar_val[gi]),
      .dec_base   (bar_base[gi*32 +: 32]),
      .programmed (bar_prog[gi]),
      .range_evt  (bar_range_chg[gi])
    );
    assign bar_enable[gi] = bar_prog[gi] &
                            (bar_val[gi][0] ? cmd[0] : cmd[1]);
  end

  logic [31:0] sel_dword, shifted, rd_data;

  always_comb begin
    sel_dword = hdr_dword;
    for (int i = 0; i < NUM_BARS; i++) begin
      if (dw_idx == DWI_W'(BAR_DW_FIRST + i)) sel_dword = bar_val[i];
    end
    shifted = sel_dword >> {lane, 3'b000};
    case (acc_size_e'(req_size))
      ACC_BYTE: rd_data = {24'h0, shifted[7:0]};
      ACC_HALF: rd_data = {16'h0, shifted[15:0]};
      default:  rd_data = shifted;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else if (fire) begin
      rsp_valid <= 1'b1;
      rsp_err   <= acc_bad | (req_write & wr_reject);
      rsp_rdata <= (req_write | acc_bad) ? 32'h0 : rd_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/cfgsp_chk.sv
module cfgsp_chk #(
  parameter int NUM_BARS  = 6,
  parameter int OFF_W     = 12,
  parameter int WIN_BYTES = 256
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic                   req_ready,
  input logic                   req_write,
  input logic [OFF_W-1:0]       req_offset,
  input logic                   rsp_valid,
  input logic                   rsp_ready,
  input logic [31:0]            rsp_rdata,
  input logic                   rsp_err,
  input logic [NUM_BARS*32-1:0] bar_base,
  input logic [NUM_BARS-1:0]    bar_range_chg
);

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)); // R12

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid); // R12

  AST_WRITE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_write |=> rsp_rdata == 32'h0); // R12

  AST_WINDOW_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && ({1'b0, req_offset} >= (OFF_W+1)'(WIN_BYTES))
    |=> rsp_err && rsp_rdata == 32'h0); // R3

  AST_BASE_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bar_base) |-> bar_range_chg != '0); // R7

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bar_range_chg)); // R7

  AST_PULSE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    bar_range_chg != '0 |-> $past(req_valid && req_ready && req_write)); // R7

endmodule

bind cfg_space_regs cfgsp_chk #(
  .NUM_BARS(NUM_BARS), .OFF_W(OFF_W), .WIN_BYTES(WIN_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_offset(req_offset), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
  .bar_base(bar_base), .bar_range_chg(bar_range_chg)
);

// File: tb/sim_cfg_space_regs.sv
module sim_cfg_space_regs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [1:0]  req_size = 2'd0;
  logic [11:0] req_offset = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic [191:0] bar_base;
  logic [5:0]  bar_enable, bar_range_chg;

  int n_chk = 0, n_bad = 0;
  logic [31:0] r_data;
  logic        r_err;
  logic [5:0]  r_chg;

  always #4 clk = ~clk;

  cfg_space_regs u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_offset(req_offset),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .bar_base(bar_base),
    .bar_enable(bar_enable), .bar_range_chg(bar_range_chg)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic wr, input logic [1:0] sz, input logic [11:0] off,
                      input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz;
    req_offset = off; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
    @(negedge clk);
    r_data = rsp_rdata; r_err = rsp_err; r_chg = bar_range_chg;
  endtask

  function automatic logic [31:0] base_of(input int i);
    return bar_base[i*32 +: 32];
  endfunction

  task automatic t_reset;
    chk("R1 bases", {26'h0, |bar_base}, 32'h0);
    chk("R1 enables", {26'h0, bar_enable}, 32'h0);
    xfer(0, 2, 12'h010, 0); chk("R1 BAR0 type", r_data, 32'h1);
    xfer(0, 2, 12'h018, 0); chk("R1 BAR2 type", r_data, 32'h8);
    xfer(0, 1, 12'h004, 0); chk("R1 command", r_data, 32'h0);
  endtask

  task automatic t_ids;
    xfer(0, 2, 12'h000, 0); chk("R2 word id", r_data, 32'h5A17C0DE);
    xfer(0, 0, 12'h001, 0); chk("R2 byte lane", r_data, 32'h000000C0);
    xfer(0, 1, 12'h002, 0); chk("R2 half lane", r_data, 32'h00005A17);
  endtask

  task automatic t_bad;
    xfer(0, 2, 12'h100, 0); chk("R3 window err", {31'h0, r_err}, 1);
    chk("R3 window data", r_data, 0);
    xfer(0, 1, 12'h001, 0); chk("R3 odd half err", {31'h0, r_err}, 1);
    xfer(0, 3, 12'h000, 0); chk("R3 size3 err", {31'h0, r_err}, 1);
    xfer(1, 2, 12'h012, 32'h0000_5000); chk("R3 misaligned word err", {31'h0, r_err}, 1);
    xfer(0, 2, 12'h014, 0); chk("R3 misaligned no change", r_data, 32'h0);
  endtask

  task automatic t_ro;
    xfer(1, 2, 12'h000, 32'h1111_2222); chk("R4 id write err", {31'h0, r_err}, 1);
    xfer(0, 2, 12'h000, 0); chk("R4 id unchanged", r_data, 32'h5A17C0DE);
    xfer(1, 2, 12'h004, 32'h0000_0003); chk("R4 status write err", {31'h0, r_err}, 1);
    xfer(0, 2, 12'h004, 0); chk("R4 command unchanged", r_data, 32'h0);
    xfer(1, 0, 12'h03C, 32'h5A); chk("R4 irq line ok", {31'h0, r_err}, 0);
    chk("R12 write rsp data", r_data, 0);
    xfer(0, 2, 12'h03C, 0); chk("R2 R4 irq dword", r_data, 32'h0000015A);
  endtask

  task automatic t_sizing;
    xfer(1, 2, 12'h010, 32'hFFFF_FFFF);
    chk("R5 sizing no err", {31'h0, r_err}, 0);
    chk("R5 sizing no pulse", {26'h0, r_chg}, 0);
    xfer(0, 2, 12'h010, 0); chk("R5 R6 io mask", r_data, 32'hFFFFFF01);
    xfer(1, 2, 12'h014, 32'hFFFF_FFFF);
    xfer(0, 2, 12'h014, 0); chk("R5 mem mask", r_data, 32'hFFFFF000);
    xfer(1, 2, 12'h018, 32'hFFFF_FFFF);
    xfer(0, 2, 12'h018, 0); chk("R5 R6 prefetch type kept", r_data, 32'hFFFF0008);
    chk("R5 base untouched", base_of(0), 0);
  endtask

  task automatic t_program;
    xfer(1, 2, 12'h010, 32'h0000_1236);
    chk("R7 io pulse", {26'h0, r_chg}, 32'h1);
    chk("R7 io base", base_of(0), 32'h4000_1234);
    xfer(0, 2, 12'h010, 0); chk("R6 io low bits kept", r_data, 32'h0000_1235);
    xfer(1, 2, 12'h014, 32'h0000_5007);
    chk("R7 mem pulse", {26'h0, r_chg}, 32'h2);
    chk("R7 mem base", base_of(1), 32'h8000_5000);
    xfer(0, 2, 12'h014, 0); chk("R6 mem low bits kept", r_data, 32'h0000_5000);
    @(negedge clk); chk("R7 pulse one cycle", {26'h0, bar_range_chg}, 0);
  endtask

  task automatic t_zero;
    xfer(1, 2, 12'h018, 32'h0000_0007);
    chk("R8 no pulse", {26'h0, r_chg}, 0);
    chk("R8 base kept", base_of(2), 0);
    xfer(0, 2, 12'h018, 0); chk("R8 stored zero", r_data, 32'h8);
    xfer(1, 2, 12'h014, 32'h0);
    chk("R8 programmed base kept", base_of(1), 32'h8000_5000);
    xfer(0, 2, 12'h014, 0); chk("R8 cleared value", r_data, 0);
  endtask

  task automatic t_enable;
    chk("R9 off without cmd", {26'h0, bar_enable}, 0);
    xfer(1, 1, 12'h004, 32'h0001);
    chk("R9 io enable", {26'h0, bar_enable}, 32'h01);
    xfer(1, 0, 12'h004, 32'h02);
    chk("R9 mem enable", {26'h0, bar_enable}, 32'h02);
  endtask

  task automatic t_zero_bar;
    xfer(1, 2, 12'h01C, 32'h1234_5670);
    chk("R10 no err", {31'h0, r_err}, 0);
    chk("R10 no pulse", {26'h0, r_chg}, 0);
    chk("R10 base zero", base_of(3), 0);
    xfer(0, 2, 12'h01C, 0); chk("R10 reads zero", r_data, 0);
    xfer(1, 0, 12'h004, 32'h03);
    chk("R10 never enabled", {31'h0, bar_enable[3]}, 0);
  endtask

  task automatic t_subword;
    xfer(1, 0, 12'h010, 32'hFF); chk("R11 byte err", {31'h0, r_err}, 1);
    xfer(1, 1, 12'h012, 32'hFFFF); chk("R11 half err", {31'h0, r_err}, 1);
    xfer(0, 2, 12'h010, 0); chk("R11 BAR0 unchanged", r_data, 32'h0000_1235);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_write = 1'b0;
    req_size = 2'd2; req_offset = 12'h000;
    @(posedge clk);
    #1 req_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R12 held valid", {31'h0, rsp_valid}, 1);
      chk("R12 held data", rsp_rdata, 32'h5A17C0DE);
      chk("R12 ready low", {31'h0, req_ready}, 0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R12 released", {31'h0, rsp_valid}, 0);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ids();
    t_bad();
    t_ro();
    t_sizing();
    t_program();
    t_zero();
    t_enable();
    t_zero_bar();
    t_subword();
    t_backpressure();
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule